// File: doc/BRIEF.md
# Nonce Hit Capture and Serial Report Queue

This block sits at the output of a fully pipelined double-hash engine. The engine delivers a new candidate result on every master clock, so a winning result is visible for exactly one cycle. The block checks the upper 32 bits of each result together with the engine's pipeline step counter. When they qualify, it takes the nonce that produced the result in that same cycle and places it in a shallow queue.

A sequencer drains the queue through an 8N1 serial transmitter. The transmitter runs on the same master clock and derives its bit period from a clock-frequency parameter and a baud-rate parameter (115200 by default). Nonces found while a report is on the wire are sent straight after it.

When the queue is full, further hits are dropped and a sticky flag records the loss. A running hit counter lets the host, or a bench, reconcile hits against reports.

Top module: `nonce_report_top`

## Requirements
- R1: A hit is recognised only in a cycle where `hash_top` is all zeros and `pipe_step` is all zeros. Any other combination leaves the counter, the queue and the line untouched.
- R2: The value stored for a hit is `cur_nonce - PIPE_LAT`, taken modulo 2^NONCE_W, so it wraps below zero.
- R3: The line idles high. Each byte is sent as one low start bit, eight data bits least significant first, and one high stop bit. Each bit lasts CLK_HZ/BAUD clocks (integer division).
- R4: A stored nonce is sent as NONCE_W/8 bytes, most significant byte first.
- R5: When more data is waiting, the next start bit begins no more than 4 clocks after the previous stop bit ends. This holds between bytes of one nonce and between queued nonces.
- R6: Hits that arrive while a report is being sent are held, up to DEPTH of them, and are sent in arrival order.
- R7: A hit that meets a full queue in a cycle with no release is dropped. It sets `ovf_flag`, which stays high until reset.
- R8: A hit that arrives in the same cycle as the queue releases its head is stored, even if the queue was full.
- R9: `hit_total` counts every hit, including dropped ones, and wraps at 2^HCNT_W.
- R10: After reset, `tx_line` is high, `ovf_flag` is low and `hit_total` is zero.

Transmitter states: TX_IDLE (line high, waiting for a start request), TX_START, TX_DATA and TX_STOP. Each state lasts one bit period. TX_DATA repeats for eight bits. TX_STOP returns to TX_IDLE and emits a done pulse.

Sequencer states: SQ_IDLE releases the queue head when the queue is not empty and moves to SQ_KICK. SQ_KICK requests a byte when the transmitter is idle and moves to SQ_WAIT. On done, SQ_WAIT goes back to SQ_KICK for the next byte, or to SQ_IDLE after the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock shared with the hash engine |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_top | input | 32 | Upper 32 bits of the outer hash result |
| pipe_step | input | STEP_W | Hash pipeline step counter |
| cur_nonce | input | NONCE_W | Nonce currently at the engine input |
| tx_line | output | 1 | Serial transmit line |
| ovf_flag | output | 1 | Sticky flag: at least one hit was dropped |
| hit_total | output | HCNT_W | Count of all hits seen |

## Verification
A wrong queue pointer or occupancy count shows up on `tx_line` as a repeated, skipped or reordered nonce. This appears at the end of the next report, which is a few hundred clocks later with the bench's bit period. A wrong drop decision shows up as an early or missing `ovf_flag` in the cycle after the hit. It also shows up as a mismatch between reports received and `hit_total` minus the drops the bench predicts. A transmitter counter off by one clock drifts the mid-bit samples by a full bit within one frame. A sequencer that stalls shows up as an inter-byte gap wider than four clocks.

// File: rtl/nrq_pkg.sv
package nrq_pkg;
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_KICK,
        SQ_WAIT
    } seq_state_e;
endpackage

// File: rtl/hit_detect.sv
module hit_detect #(
    parameter int HASH_W   = 32,
    parameter int STEP_W   = 6,
    parameter int NONCE_W  = 32,
    parameter int PIPE_LAT = 0
) (
    input  logic [HASH_W-1:0]  hash_top,
    input  logic [STEP_W-1:0]  pipe_step,
    input  logic [NONCE_W-1:0] cur_nonce,
    output logic               hit,
    output logic [NONCE_W-1:0] cap_nonce
);
    localparam logic [NONCE_W-1:0] LAT_V = NONCE_W'(PIPE_LAT);

    always_comb begin
        hit       = (hash_top == '0) && (pipe_step == '0);
        cap_nonce = cur_nonce - LAT_V;
    end
endmodule

// File: rtl/nonce_fifo.sv
module nonce_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push_req,
    input  logic                           pop,
    input  logic [W-1:0]                   din,
    output logic [W-1:0]                   dout,
    output logic                           empty,
    output logic                           full,
    output logic                           ovf,
    output logic [$clog2(DEPTH+1)-1:0]     level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          accept;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty  = (count == '0);
        full   = (count == CW'(DEPTH));
        accept = push_req && (!full || pop);
        dout   = mem[rd_ptr];
        level  = count;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (accept) wr_ptr <= step_ptr(wr_ptr);
            if (pop)    rd_ptr <= step_ptr(rd_ptr);
            unique case ({accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push_req && full && !pop) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_byte.sv
module uart_tx_byte
    import nrq_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       ready,
    output logic       done,
    output logic       tx
);
    localparam int BIT_CYC = CLK_HZ / BAUD;
    localparam int CNT_W   = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BIT_CYC - 1);

    tx_state_e        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shreg;
    logic             bit_end;

    assign bit_end = (cnt == CNT_END);

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (start)   nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && bit_idx == 3'd7) nxt = TX_STOP;
            TX_STOP:  if (bit_end) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            done    <= 1'b0;
        end else begin
            done <= (state == TX_STOP) && bit_end;
            if (state == TX_IDLE) begin
                cnt     <= '0;
                bit_idx <= '0;
                if (start) shreg <= data;
            end else if (bit_end) begin
                cnt <= '0;
                if (state == TX_DATA) begin
                    bit_idx <= bit_idx + 1'b1;
                    shreg   <= {1'b0, shreg[7:1]};
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        ready = (state == TX_IDLE);
        unique case (state)
            TX_START: tx = 1'b0;
            TX_DATA:  tx = shreg[0];
            default:  tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/nonce_report_top.sv
module nonce_report_top
    import nrq_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int BAUD     = 115_200,
    parameter int NONCE_W  = 32,
    parameter int STEP_W   = 6,
    parameter int PIPE_LAT = 0,
    parameter int DEPTH    = 4,
    parameter int HCNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        hash_top,
    input  logic [STEP_W-1:0]  pipe_step,
    input  logic [NONCE_W-1:0] cur_nonce,
    output logic               tx_line,
    output logic               ovf_flag,
    output logic [HCNT_W-1:0]  hit_total
);
    localparam int BYTES = NONCE_W / 8;
    localparam int IW    = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam logic [IW-1:0] LAST_BYTE = IW'(BYTES - 1);

    logic               hit;
    logic [NONCE_W-1:0] cap_nonce;
    logic [NONCE_W-1:0] q_head;
    logic               q_empty, q_full, q_pop;
    logic [CW-1:0]      q_level;
    logic               u_start, u_ready, u_done;
    seq_state_e         seq_q, seq_d;
    logic [NONCE_W-1:0] word_q;
    logic [IW-1:0]      idx_q;

    hit_detect #(
        .HASH_W(32), .STEP_W(STEP_W), .NONCE_W(NONCE_W), .PIPE_LAT(PIPE_LAT)
    ) u_hit (
        .hash_top(hash_top), .pipe_step(pipe_step), .cur_nonce(cur_nonce),
        .hit(hit), .cap_nonce(cap_nonce)
    );

    nonce_fifo #(.W(NONCE_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(hit), .pop(q_pop),
        .din(cap_nonce), .dout(q_head), .empty(q_empty), .full(q_full),
        .ovf(ovf_flag), .level(q_level)
    );

    uart_tx_byte #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(u_start),
        .data(word_q[NONCE_W-1 -: 8]), .ready(u_ready), .done(u_done),
        .tx(tx_line)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SQ_IDLE: if (!q_empty) seq_d = SQ_KICK;
            SQ_KICK: if (u_ready)  seq_d = SQ_WAIT;
            SQ_WAIT: if (u_done)   seq_d = (idx_q == LAST_BYTE) ? SQ_IDLE : SQ_KICK;
            default: seq_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SQ_IDLE;
        else        seq_q <= seq_d;
    end

    always_comb begin
        q_pop   = (seq_q == SQ_IDLE) && !q_empty;
        u_start = (seq_q == SQ_KICK) && u_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            idx_q     <= '0;
            hit_total <= '0;
        end else begin
            if (hit) hit_total <= hit_total + 1'b1;
            if (q_pop) begin
                word_q <= q_head;
                idx_q  <= '0;
            end else if (seq_q == SQ_WAIT && u_done && idx_q != LAST_BYTE) begin
                word_q <= {word_q[NONCE_W-9:0], 8'h00};
                idx_q  <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/report_chk.sv
module report_chk
    import nrq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int HCNT_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       hit,
    input logic                       q_full,
    input logic                       q_pop,
    input logic [$clog2(DEPTH+1)-1:0] q_level,
    input logic                       ovf_flag,
    input logic [HCNT_W-1:0]          hit_total,
    input seq_state_e                 seq_q,
    input logic                       u_ready,
    input logic                       tx_line
);
    localparam int CW = $clog2(DEPTH + 1);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R7
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && q_full && !q_pop) |=> ovf_flag);

    // R8
    admit_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && q_full && q_pop) |=> (q_level == CW'(DEPTH)));

    // R8
    admit_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && q_full && q_pop && !ovf_flag) |=> !ovf_flag);

    // R6
    store_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !q_full && !q_pop) |=> (q_level == $past(q_level) + 1'b1));

    // R9
    hit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (hit_total == $past(hit_total) + 1'b1));

    // R3
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SQ_IDLE && u_ready) |-> tx_line);
endmodule

bind nonce_report_top report_chk #(.DEPTH(DEPTH), .HCNT_W(HCNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hit(hit), .q_full(q_full), .q_pop(q_pop),
    .q_level(q_level), .ovf_flag(ovf_flag), .hit_total(hit_total),
    .seq_q(seq_q), .u_ready(u_ready), .tx_line(tx_line)
);

// File: tb/sim_nonce_report_top.sv
module sim_nonce_report_top;
    localparam int CLK_HZ = 50_000_000;
    localparam int BAUD   = 5_000_000;
    localparam int BIT    = CLK_HZ / BAUD;
    localparam int DEPTH  = 4;
    localparam int LAT    = 5;
    localparam int HCNT_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hash_top;
    logic [5:0]  pipe_step;
    logic [31:0] cur_nonce;
    logic        tx_line, ovf_flag;
    logic [HCNT_W-1:0] hit_total;

    always #10 clk = ~clk;

    nonce_report_top #(
        .CLK_HZ(CLK_HZ), .BAUD(BAUD), .NONCE_W(32), .STEP_W(6),
        .PIPE_LAT(LAT), .DEPTH(DEPTH), .HCNT_W(HCNT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .hash_top(hash_top), .pipe_step(pipe_step),
        .cur_nonce(cur_nonce), .tx_line(tx_line), .ovf_flag(ovf_flag),
        .hit_total(hit_total)
    );

    typedef struct { logic [31:0] lo; logic [31:0] hi; } exp_t;
    exp_t exp_q[$];

    int checks = 0, errors = 0;
    int hits_driven = 0, dropped_model = 0, words_rx = 0, starts = 0;
    bit tight = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_exp(input logic [31:0] lo, input logic [31:0] hi);
        exp_t e;
        e.lo = lo;
        e.hi = hi;
        exp_q.push_back(e);
    endtask

    task automatic drv_idle();
        hash_top  = 32'h0BAD_F00D;
        pipe_step = 6'd1;
    endtask

    task automatic drv_hit(input logic [31:0] n);
        hash_top  = 32'h0;
        pipe_step = 6'd0;
        cur_nonce = n;
        hits_driven++;
    endtask

    task automatic send_one(input logic [31:0] n);
        drv_hit(n);
        push_exp(n - 32'(LAT), n - 32'(LAT));
        @(negedge clk);
        drv_idle();
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (3 * BIT) @(negedge clk);
    endtask

    // Scoreboard monitor: decodes the serial line and compares to expectations
    initial begin
        wait (rst_n == 1'b1);
        forever begin
            logic [31:0] w;
            logic [7:0]  by;
            w = '0;
            for (int b = 0; b < 4; b++) begin
                int gap;
                gap = 0;
                do begin
                    @(negedge clk);
                    gap++;
                end while (tx_line == 1'b1);
                if (b > 0 || tight)
                    chk(gap <= BIT / 2 + 4, "R5 gap before start bit", 32'(gap), 32'(BIT / 2 + 4));
                if (b == 0) starts++;
                repeat (BIT / 2) @(negedge clk);
                chk(tx_line == 1'b0, "R3 start bit", {31'd0, tx_line}, 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT) @(negedge clk);
                    by[i] = tx_line;
                end
                repeat (BIT) @(negedge clk);
                chk(tx_line == 1'b1, "R3 stop bit", {31'd0, tx_line}, 32'd1);
                w = {w[23:0], by};
            end
            words_rx++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected word", w, 32'h0);
                tight = 1'b0;
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(w >= e.lo && w <= e.hi, "R2 R4 R6 word value", w, e.lo);
                tight = (exp_q.size() > 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", words_rx, hits_driven - dropped_model);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        drv_idle();
        cur_nonce = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(tx_line == 1'b1, "R10 line idle", {31'd0, tx_line}, 32'd1);
        chk(ovf_flag == 1'b0, "R10 flag clear", {31'd0, ovf_flag}, 32'd0);
        chk(hit_total == '0, "R10 counter zero", 32'(hit_total), 32'd0);

        // single report
        send_one(32'h1234_5678);
        drain();

        // R1 near-miss patterns must not count or transmit
        hash_top = 32'h0000_0001; pipe_step = 6'd0; @(negedge clk);
        hash_top = 32'h0;         pipe_step = 6'd3; @(negedge clk);
        hash_top = 32'h8000_0000; pipe_step = 6'd0; @(negedge clk);
        hash_top = 32'h0;         pipe_step = 6'd32; @(negedge clk);
        drv_idle();
        repeat (20 * BIT) @(negedge clk);
        chk(hit_total == 16'd1, "R1 counter after near misses", 32'(hit_total), 32'd1);
        chk(starts == 1, "R1 no extra report", 32'(starts), 32'd1);

        // R2 wrap below zero
        send_one(32'h0000_0002);
        drain();

        // R5 R6 two hits close together
        send_one(32'hA5C3_0F81);
        repeat (4) @(negedge clk);
        send_one(32'h5A3C_F018);
        drain();

        // R7 overflow
        chk(ovf_flag == 1'b0, "R7 flag before overflow", {31'd0, ovf_flag}, 32'd0);
        send_one(32'h7000_0000);
        repeat (20) @(negedge clk);
        for (int i = 0; i < DEPTH + 2; i++) begin
            drv_hit(32'h4000_0000 + 32'(i * 16));
            if (i < DEPTH)
                push_exp(32'h4000_0000 + 32'(i * 16) - 32'(LAT),
                         32'h4000_0000 + 32'(i * 16) - 32'(LAT));
            else
                dropped_model++;
            @(negedge clk);
        end
        drv_idle();
        chk(ovf_flag == 1'b1, "R7 flag after drop", {31'd0, ovf_flag}, 32'd1);

        // R8 hit stream across the cycle in which a full queue releases its head
        begin
            int k;
            int s0;
            k  = 0;
            s0 = starts;
            while (1) begin
                @(negedge clk);
                #1;
                if (starts != s0) break;
                drv_hit(32'h2000_0000 + 32'(k));
                k++;
            end
            drv_idle();
            dropped_model += k - 1;
            push_exp(32'h2000_0000 - 32'(LAT), 32'h2000_0000 + 32'(k - 1) - 32'(LAT));
        end
        @(negedge clk);
        drain();
        repeat (30 * BIT) @(negedge clk);

        chk(ovf_flag == 1'b1, "R7 flag sticky", {31'd0, ovf_flag}, 32'd1);
        chk(hit_total == HCNT_W'(hits_driven), "R9 hit counter", 32'(hit_total), 32'(hits_driven));
        chk(words_rx == hits_driven - dropped_model, "R8 reports equal hits minus drops",
            32'(words_rx), 32'(hits_driven - dropped_model));
        chk(exp_q.size() == 0, "R6 all queued words sent", 32'(exp_q.size()), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule